// File: doc/BRIEF.md
# Privilege and Exception Return Controller

This block is the privilege slice of a processor's system control coprocessor. It records whether the core is running in user or kernel mode. It turns privileged operations issued from user mode into traps, so that a hypervisor running in kernel mode can emulate them for an unmodified guest. It takes exceptions from address-translation misses and from the timer. It also handles the return from an exception. For each exception it accepts, it stores the faulting program counter and a 5-bit reason code, switches to kernel mode and asks the fetch stage to redirect to a fixed vector address.

The pipeline presents one instruction per cycle. It qualifies the instruction with `instr_valid` and supplies its class flags and PC. The translation unit and the timer raise their request lines in the cycle they apply. All pins are plain control and status signals that are sampled every cycle. No pin has a handshake and no pin can apply back-pressure. The redirect output is a one-cycle pulse, and fetch must act on it in the cycle it is high. Kernel software can overwrite the saved PC through a write port. A handler uses this to step past an emulated instruction (saved PC + 4) before it returns.

Top module: `priv_exc_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in kernel mode (`user_mode`=0), `redirect_valid` is 0, and `epc_value` and `cause_code` are 0.
- R2: A valid instruction flagged as a coprocessor move or as an exception return, issued in user mode, is trapped. In the next cycle the mode is kernel and `cause_code` is 11. The same instruction flags in kernel mode cause no trap.
- R3: Every accepted exception makes, in the next cycle, `user_mode`=0, `redirect_valid`=1 and `redirect_pc`=0x80000180 (parameter `VEC_ADDR`).
- R4: On an accepted exception, `epc_value` becomes the `instr_pc` presented in the cycle of the exception.
- R5: A translation miss is accepted in either mode. A miss on load or fetch gives code 2 and a miss on store gives code 3. If both are raised together, code 2 is reported.
- R6: A timer request is accepted only in user mode, with code 0. In kernel mode it has no effect on mode, redirect, saved PC or cause.
- R7: When several causes occur in one cycle, the privileged trap wins over a translation miss, and a translation miss wins over the timer request.
- R8: A valid return instruction in kernel mode, with no exception in the same cycle, gives in the next cycle `user_mode`=1, `redirect_valid`=1 and `redirect_pc` equal to the saved PC held before that cycle.
- R9: `epc_wr_en` in kernel mode loads `epc_wr_data` into the saved PC. In user mode the write is ignored. An exception capture in the same cycle takes precedence over the write.
- R10: In a cycle with no accepted exception and no accepted return, `redirect_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_is_cop_move | input | 1 | Issued instruction reads or writes a coprocessor register |
| instr_is_eret | input | 1 | Issued instruction is an exception return |
| instr_pc | input | ADDR_W | PC of the current instruction or of the faulting access |
| tlb_miss_load | input | 1 | Translation miss on load or fetch |
| tlb_miss_store | input | 1 | Translation miss on store |
| timer_irq | input | 1 | Timer interrupt request |
| epc_wr_en | input | 1 | Software write of the saved PC |
| epc_wr_data | input | ADDR_W | Value for the software write |
| user_mode | output | 1 | 1 = user mode, 0 = kernel mode |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | ADDR_W | Redirect target |
| epc_value | output | ADDR_W | Saved exception PC |
| cause_code | output | 5 | Code of the last accepted exception |

## Verification
Every output is taken from a register. The result of inputs driven in one cycle therefore appears one clock edge later: mode, redirect pulse, saved PC and cause all change together on that edge. The bench drives inputs on the falling edge and advances its model at the same point. It then compares all outputs on the next falling edge, half a period after the register update. An exception return is checked against the saved PC as it stood before the return cycle. This matters in the cycle where a software write to the saved PC coincides with the return.

// File: rtl/priv_exc_pkg.sv
package priv_exc_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    CODE_IRQ      = 5'd0,
    CODE_MISS_LD  = 5'd2,
    CODE_MISS_ST  = 5'd3,
    CODE_PRIV     = 5'd11
  } exc_code_e;
endpackage

// File: rtl/pec_cause_arb.sv
module pec_cause_arb
  import priv_exc_pkg::*;
(
  input  logic       user_mode,
  input  logic       instr_valid,
  input  logic       instr_is_cop_move,
  input  logic       instr_is_eret,
  input  logic       tlb_miss_load,
  input  logic       tlb_miss_store,
  input  logic       timer_irq,
  output logic       take,
  output exc_code_e  code
);
  logic priv_hit;
  logic miss_hit;
  logic irq_hit;

  // Operations reserved for kernel software trap when issued from user mode.
  assign priv_hit = instr_valid && user_mode && (instr_is_cop_move || instr_is_eret);
  assign miss_hit = tlb_miss_load || tlb_miss_store;
  // Interrupts are held off while a kernel handler runs.
  assign irq_hit  = timer_irq && user_mode;

  assign take = priv_hit || miss_hit || irq_hit;

  always_comb begin
    if (priv_hit)           code = CODE_PRIV;
    else if (tlb_miss_load) code = CODE_MISS_LD;
    else if (tlb_miss_store) code = CODE_MISS_ST;
    else                    code = CODE_IRQ;
  end
endmodule

// File: rtl/pec_epc_store.sv
module pec_epc_store #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] capture_pc,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_data,
  output logic [ADDR_W-1:0] epc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc <= '0;
    else if (capture) epc <= capture_pc;
    else if (sw_wr)   epc <= sw_data;
  end
endmodule

// File: rtl/pec_mode_reg.sv
module pec_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic to_kernel,
  input  logic to_user,
  output logic user_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         user_mode <= 1'b0;
    else if (to_kernel) user_mode <= 1'b0;
    else if (to_user)   user_mode <= 1'b1;
  end
endmodule

// File: rtl/priv_exc_ctrl.sv
module priv_exc_ctrl
  import priv_exc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              instr_is_cop_move,
  input  logic              instr_is_eret,
  input  logic [ADDR_W-1:0] instr_pc,
  input  logic              tlb_miss_load,
  input  logic              tlb_miss_store,
  input  logic              timer_irq,
  input  logic              epc_wr_en,
  input  logic [ADDR_W-1:0] epc_wr_data,
  output logic              user_mode,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] epc_value,
  output logic [CODE_W-1:0] cause_code
);
  logic      exc_take;
  exc_code_e exc_code;
  logic      ret_take;
  logic      epc_sw_wr;

  pec_cause_arb arb_i (
    .user_mode         (user_mode),
    .instr_valid       (instr_valid),
    .instr_is_cop_move (instr_is_cop_move),
    .instr_is_eret     (instr_is_eret),
    .tlb_miss_load     (tlb_miss_load),
    .tlb_miss_store    (tlb_miss_store),
    .timer_irq         (timer_irq),
    .take              (exc_take),
    .code              (exc_code)
  );

  // Return is honoured only from kernel mode and only when nothing traps.
  assign ret_take  = instr_valid && instr_is_eret && !user_mode && !exc_take;
  assign epc_sw_wr = epc_wr_en && !user_mode;

  pec_epc_store #(.ADDR_W(ADDR_W)) epc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (exc_take),
    .capture_pc (instr_pc),
    .sw_wr      (epc_sw_wr),
    .sw_data    (epc_wr_data),
    .epc        (epc_value)
  );

  pec_mode_reg mode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .to_kernel (exc_take),
    .to_user   (ret_take),
    .user_mode (user_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_code     <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= exc_take || ret_take;
      if (exc_take) begin
        cause_code  <= exc_code;
        redirect_pc <= VEC_ADDR;
      end else if (ret_take) begin
        redirect_pc <= epc_value;
      end
    end
  end
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 32'h8000_0180
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_is_cop_move,
  input logic              instr_is_eret,
  input logic [ADDR_W-1:0] instr_pc,
  input logic              tlb_miss_load,
  input logic              tlb_miss_store,
  input logic              timer_irq,
  input logic              epc_wr_en,
  input logic              user_mode,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic [ADDR_W-1:0] epc_value,
  input logic [4:0]        cause_code
);
  logic priv_ev, miss_ev, irq_ev, any_ev, ret_ev;
  assign priv_ev = instr_valid && user_mode && (instr_is_cop_move || instr_is_eret);
  assign miss_ev = tlb_miss_load || tlb_miss_store;
  assign irq_ev  = timer_irq && user_mode;
  assign any_ev  = priv_ev || miss_ev || irq_ev;
  assign ret_ev  = instr_valid && instr_is_eret && !user_mode && !any_ev;

  AST_RESET_KERNEL: assert property (@(posedge clk)
    !rst_n |=> !user_mode && !redirect_valid); // R1

  AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    priv_ev |=> !user_mode && cause_code == 5'd11 && epc_value == $past(instr_pc)); // R2

  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> !user_mode && redirect_valid && redirect_pc == VEC_ADDR); // R3

  AST_MISS_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_ev && tlb_miss_load) |=> cause_code == 5'd2); // R5

  AST_PRIO_MISS_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_ev && !tlb_miss_load && tlb_miss_store) |=> cause_code == 5'd3); // R7

  AST_KERNEL_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && timer_irq && !miss_ev && !instr_valid && !epc_wr_en)
      |=> !redirect_valid && $stable(epc_value) && $stable(cause_code)); // R6

  AST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ev |=> user_mode && redirect_valid && redirect_pc == $past(epc_value)); // R8

  AST_USER_EPC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && epc_wr_en && !any_ev) |=> $stable(epc_value)); // R9

  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ev && !ret_ev) |=> !redirect_valid); // R10
endmodule

bind priv_exc_ctrl pec_checker #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .instr_valid       (instr_valid),
  .instr_is_cop_move (instr_is_cop_move),
  .instr_is_eret     (instr_is_eret),
  .instr_pc          (instr_pc),
  .tlb_miss_load     (tlb_miss_load),
  .tlb_miss_store    (tlb_miss_store),
  .timer_irq         (timer_irq),
  .epc_wr_en         (epc_wr_en),
  .user_mode         (user_mode),
  .redirect_valid    (redirect_valid),
  .redirect_pc       (redirect_pc),
  .epc_value         (epc_value),
  .cause_code        (cause_code)
);

// File: tb/priv_exc_ctrl_tb_top.sv
module priv_exc_ctrl_tb_top;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0, instr_is_cop_move = 1'b0, instr_is_eret = 1'b0;
  logic [31:0] instr_pc = '0;
  logic        tlb_miss_load = 1'b0, tlb_miss_store = 1'b0, timer_irq = 1'b0;
  logic        epc_wr_en = 1'b0;
  logic [31:0] epc_wr_data = '0;
  logic        user_mode, redirect_valid;
  logic [31:0] redirect_pc, epc_value;
  logic [4:0]  cause_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Model state derived from the requirements.
  logic        m_user = 1'b0;
  logic [31:0] m_epc = '0;
  logic [4:0]  m_cause = '0;
  logic        m_rv = 1'b0;
  logic [31:0] m_rpc = '0;

  always #4 clk = ~clk;

  priv_exc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_is_cop_move(instr_is_cop_move),
    .instr_is_eret(instr_is_eret), .instr_pc(instr_pc),
    .tlb_miss_load(tlb_miss_load), .tlb_miss_store(tlb_miss_store),
    .timer_irq(timer_irq), .epc_wr_en(epc_wr_en), .epc_wr_data(epc_wr_data),
    .user_mode(user_mode), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .epc_value(epc_value), .cause_code(cause_code)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Priority-ordered exception code (R5, R7).
  function automatic logic [4:0] exp_code(input logic priv, input logic tl, input logic ts);
    if (priv)    return 5'd11;
    else if (tl) return 5'd2;
    else if (ts) return 5'd3;
    else         return 5'd0;
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "user_mode", {31'd0, user_mode}, {31'd0, m_user});
    chk(tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, m_rv});
    if (m_rv) chk(tag, "redirect_pc", redirect_pc, m_rpc);
    chk(tag, "epc_value", epc_value, m_epc);
    chk(tag, "cause_code", {27'd0, cause_code}, {27'd0, m_cause});
  endtask

  // Drive one cycle of stimulus at a falling edge, then check at the next one.
  task automatic step(input logic iv, input logic cop, input logic er,
                      input logic [31:0] pc, input logic tl, input logic ts,
                      input logic irq, input logic we, input logic [31:0] wd);
    logic priv, irq_ok, exc, ret;
    string tag;
    instr_valid = iv; instr_is_cop_move = cop; instr_is_eret = er;
    instr_pc = pc; tlb_miss_load = tl; tlb_miss_store = ts;
    timer_irq = irq; epc_wr_en = we; epc_wr_data = wd;
    priv   = iv && m_user && (cop || er);
    irq_ok = irq && m_user;
    exc    = priv || tl || ts || irq_ok;
    ret    = iv && er && !m_user && !exc;
    if (priv && (tl || ts || irq_ok)) tag = "R7";
    else if (priv)            tag = "R2";
    else if (tl || ts)        tag = "R5";
    else if (irq_ok)          tag = "R6";
    else if (ret)             tag = "R8";
    else if (we)              tag = "R9";
    else if (irq)             tag = "R6";
    else                      tag = "R10";
    if (exc) begin
      m_rv = 1'b1; m_rpc = VEC; m_user = 1'b0;
      m_cause = exp_code(priv, tl, ts); m_epc = pc;    // R3 R4
    end else if (ret) begin
      m_rv = 1'b1; m_rpc = m_epc; m_user = 1'b1;
      if (we) m_epc = wd;
    end else begin
      m_rv = 1'b0;
      if (we && !m_user) m_epc = wd;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare_all("R1");                      // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");                      // R1 after release
    // Kernel-mode coprocessor move: no trap (R2).
    step(1'b1, 1'b1, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    // Kernel timer request is masked (R6).
    step(1'b0, 1'b0, 1'b0, 32'h104, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    // Kernel write then return to user (R9, R8).
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0070);
    step(1'b1, 1'b0, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    idle();                                 // R10
    // User-mode write ignored (R9).
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    // User coprocessor move traps (R2, R3, R4).
    step(1'b1, 1'b1, 1'b0, 32'h0000_0070, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    // Handler advances saved PC by 4 and returns; same-cycle write uses old EPC (R8, R9).
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0074);
    step(1'b1, 1'b0, 1'b1, 32'h300, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0999);
    // User return instruction traps (R2).
    step(1'b1, 1'b0, 1'b1, 32'h0000_0074, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    step(1'b1, 1'b0, 1'b1, 32'h304, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    // All causes at once in user mode: privileged wins (R7).
    step(1'b1, 1'b1, 1'b0, 32'h0000_0400, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1);
    // Kernel-mode miss, both kinds: load code wins (R5); write loses to capture (R9).
    step(1'b0, 1'b0, 1'b0, 32'h0000_0500, 1'b1, 1'b1, 1'b0, 1'b1, 32'h2);
    step(1'b1, 1'b0, 1'b1, 32'h504, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    // Store miss over timer in user mode (R7, R5).
    step(1'b0, 1'b0, 1'b0, 32'h0000_0600, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
    step(1'b1, 1'b0, 1'b1, 32'h604, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    // User timer interrupt (R6).
    step(1'b0, 1'b0, 1'b0, 32'h0000_0700, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    // Constrained random traffic with rare events.
    for (int i = 0; i < 3000; i++) begin
      logic iv, cop, er, tl, ts, irq, we;
      iv  = ($urandom % 4) != 0;
      cop = iv && (($urandom % 6) == 0);
      er  = iv && !cop && (($urandom % 4) == 0);
      tl  = ($urandom % 16) == 0;
      ts  = ($urandom % 16) == 0;
      irq = ($urandom % 10) == 0;
      we  = ($urandom % 8) == 0;
      step(iv, cop, er, {$urandom} & 32'hFFFF_FFFC, tl, ts, irq, we, $urandom);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule